// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block keeps the interrupt enable mask and the sticky interrupt status word of a memory-mapped serial port, and drives the single level-sensitive interrupt line of that port. The FIFO and receiver logic around it feed it their conditions. Some of these are levels: the FIFO full, empty and trigger flags, which arrive packed in a raw status word. Others are single-cycle pulses: receive overrun, receive timeout and transmit overrun. Each condition that is present sets its bit in the status word. The bit then stays set until software clears it.

Software reaches the unit through a small register port. It has a write strobe, a read strobe and a two-bit word address. The mask can be changed only through two write-only registers. One of them sets bits in the mask and the other clears bits. A third address shows the mask for reading, and writes to that address are ignored. The status register is cleared one bit at a time by writing ones to it. The port has no data stream: every pin is a plain control or status signal, so there is no back-pressure to manage.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask and the status word both read as zero, and the interrupt line is low.
- R2: A write to word address 0 ORs the write data into the mask.
- R3: A write to word address 1 clears every mask bit that is 1 in the write data and leaves the other mask bits unchanged.
- R4: A write to word address 2 leaves the mask unchanged. A read at word address 2 returns the mask.
- R5: A write to word address 3 clears each status bit written as 1 and leaves the bits written as 0 unchanged. A read at word address 3 returns the status word.
- R6: Raw status bits 0 to 4 (receive trigger, receive empty, receive full, transmit empty, transmit full) set the same bit positions of the status word in every cycle in which they are high. Those status bits stay set after the raw bits fall.
- R7: Raw status bit 13 (transmit trigger) sets bit 10 of the status word.
- R8: A receive overrun pulse sets status bit 5, a receive timeout pulse sets status bit 8, and a transmit overrun pulse sets status bit 12.
- R9: When a hardware set and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R10: The interrupt line is registered. In each cycle it equals the OR of (mask AND status) as that value stood one clock earlier.
- R11: Reads at word addresses 0 and 1 return zero. Read data is zero whenever the read strobe is low.
- R12: Raw status bits other than 0 to 4 and 13 have no effect. Status bits other than 0 to 5, 8, 10 and 12 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address (0 set-mask, 1 clear-mask, 2 mask view, 3 status) |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, combinational from address and state |
| raw_status | input | REG_W | Raw FIFO condition flags (bits 0..4 and 13 used) |
| rx_ovr_evt | input | 1 | Receive overrun pulse |
| rx_tmo_evt | input | 1 | Receive timeout pulse |
| tx_ovr_evt | input | 1 | Transmit overrun pulse |
| irq | output | 1 | Registered level interrupt |

## Verification
The hardest case to reach is a hardware set and a software clear landing on the same status bit in the same cycle. Any rule other than "set wins" would drop an event without a trace. The stimulus holds a raw flag high while it writes a one to that flag's status bit, and it does the same for a single-cycle overrun pulse. It then reads the status word back. A long stretch of random writes, reads and events follows. The bench compares the read data and the interrupt line against its reference model on every clock, so the one-clock lag of the interrupt line is checked at every mask and status change.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [1:0] {
    ADR_MASK_SET  = 2'd0,
    ADR_MASK_CLR  = 2'd1,
    ADR_MASK_VIEW = 2'd2,
    ADR_STATUS    = 2'd3
  } irq_reg_e;

  localparam int RAW_LOW_FLAGS = 5;   // raw bits 0..4 map straight through
  localparam int RAW_TTRIG_POS = 13;  // transmit trigger in the raw word
  localparam int STS_RXOVR_POS = 5;
  localparam int STS_TMO_POS   = 8;
  localparam int STS_TTRIG_POS = 10;
  localparam int STS_TXOVR_POS = 12;
endpackage

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (set_en) mask_q <= mask_q | wdata;
    else if (clr_en) mask_q <= mask_q & ~wdata;
  end

  assert_mask_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((mask_q & $past(wdata)) == $past(wdata)));
  assert_mask_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((mask_q & $past(wdata)) == '0));
  assert_mask_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(mask_q));
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] raw_status,
  input  logic             rx_ovr_evt,
  input  logic             rx_tmo_evt,
  input  logic             tx_ovr_evt,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_bits,
  output logic [REG_W-1:0] sts_q
);
  localparam logic [REG_W-1:0] LOW_MASK = REG_W'((1 << RAW_LOW_FLAGS) - 1);
  localparam logic [REG_W-1:0] IMPL_MASK = LOW_MASK
    | (REG_W'(1) << STS_RXOVR_POS) | (REG_W'(1) << STS_TMO_POS)
    | (REG_W'(1) << STS_TTRIG_POS) | (REG_W'(1) << STS_TXOVR_POS);

  logic [REG_W-1:0] hw_set;
  logic [REG_W-1:0] clr_vec;

  always_comb begin
    hw_set = raw_status & LOW_MASK;
    hw_set[STS_RXOVR_POS] = rx_ovr_evt;
    hw_set[STS_TMO_POS]   = rx_tmo_evt;
    hw_set[STS_TTRIG_POS] = raw_status[RAW_TTRIG_POS];
    hw_set[STS_TXOVR_POS] = tx_ovr_evt;
    clr_vec = clr_en ? clr_bits : '0;
  end

  // hardware set takes priority over a write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= ((sts_q & ~clr_vec) | hw_set) & IMPL_MASK;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(hw_set)) == $past(hw_set)));
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((sts_q & $past(clr_bits) & ~$past(hw_set)) == '0));
  assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~IMPL_MASK) == '0);
endmodule

// File: rtl/uart_irq_out.sv
module uart_irq_out #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] mask_q,
  input  logic [REG_W-1:0] sts_q,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(mask_q & sts_q);
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [REG_W-1:0] raw_status,
  input  logic             rx_ovr_evt,
  input  logic             rx_tmo_evt,
  input  logic             tx_ovr_evt,
  output logic             irq
);
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] sts_q;
  logic wr_set, wr_clr, wr_sts;

  assign wr_set = reg_wr && (reg_addr == ADR_MASK_SET);
  assign wr_clr = reg_wr && (reg_addr == ADR_MASK_CLR);
  assign wr_sts = reg_wr && (reg_addr == ADR_STATUS);

  uart_irq_mask #(.REG_W(REG_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_en(wr_set), .clr_en(wr_clr),
    .wdata(reg_wdata), .mask_q(mask_q)
  );

  uart_irq_status #(.REG_W(REG_W)) u_status (
    .clk(clk), .rst_n(rst_n), .raw_status(raw_status),
    .rx_ovr_evt(rx_ovr_evt), .rx_tmo_evt(rx_tmo_evt), .tx_ovr_evt(tx_ovr_evt),
    .clr_en(wr_sts), .clr_bits(reg_wdata), .sts_q(sts_q)
  );

  uart_irq_out #(.REG_W(REG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mask_q(mask_q), .sts_q(sts_q), .irq_q(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        ADR_MASK_VIEW: reg_rdata = mask_q;
        ADR_STATUS:    reg_rdata = sts_q;
        default:       reg_rdata = '0;
      endcase
    end
  end

  assert_view_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_MASK_VIEW) |=> $stable(mask_q));
  assert_irq_lags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(mask_q & sts_q)));
  assert_wo_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd || reg_addr == ADR_MASK_SET || reg_addr == ADR_MASK_CLR) |-> (reg_rdata == '0));
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0, raw_status = '0;
  logic         rx_ovr_evt = 1'b0, rx_tmo_evt = 1'b0, tx_ovr_evt = 1'b0;
  logic [W-1:0] reg_rdata;
  logic         irq;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [W-1:0] m_mask = '0, m_sts = '0;
  logic         m_irq = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ctrl #(.REG_W(W)) u_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .raw_status(raw_status), .rx_ovr_evt(rx_ovr_evt), .rx_tmo_evt(rx_tmo_evt),
    .tx_ovr_evt(tx_ovr_evt), .irq(irq)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // one clock: drive at negedge, compare, then let the model take the edge
  task automatic cyc(input bit wr, input bit rd, input logic [1:0] a,
                     input logic [W-1:0] d, input logic [W-1:0] raw,
                     input bit ro, input bit to, input bit tx, input string req);
    logic [W-1:0] exp_rd;
    logic [W-1:0] setv;
    logic [W-1:0] clrv;
    logic         nirq;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    raw_status = raw; rx_ovr_evt = ro; rx_tmo_evt = to; tx_ovr_evt = tx;
    #1;
    exp_rd = '0;
    if (rd && a == 2'd2) exp_rd = m_mask;
    if (rd && a == 2'd3) exp_rd = m_sts;
    vectors++;
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s irq actual %0b expected %0b", req, irq, m_irq);
    end
    vectors++;
    if (reg_rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s rdata actual %h expected %h", req, reg_rdata, exp_rd);
    end
    @(posedge clk);
    nirq = |(m_mask & m_sts);
    setv = '0;
    setv[4:0] = raw[4:0];
    setv[5]   = ro;
    setv[8]   = to;
    setv[10]  = raw[13];
    setv[12]  = tx;
    clrv = (wr && a == 2'd3) ? d : '0;
    m_sts = (m_sts & ~clrv) | setv;
    if (wr && a == 2'd0) m_mask = m_mask | d;
    else if (wr && a == 2'd1) m_mask = m_mask & ~d;
    m_irq = nirq;
  endtask

  task automatic rd_reg(input logic [1:0] a, input string req);
    cyc(0, 1, a, '0, '0, 0, 0, 0, req);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [W-1:0] d, input string req);
    cyc(1, 0, a, d, '0, 0, 0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    rd_reg(2'd2, "R1");
    rd_reg(2'd3, "R1");
    // R2: set-mask ORs
    wr_reg(2'd0, 32'h0000_0021, "R2");
    rd_reg(2'd2, "R2");
    wr_reg(2'd0, 32'h0000_0400, "R2");
    rd_reg(2'd2, "R2");
    // R4: mask view write ignored
    wr_reg(2'd2, 32'hFFFF_FFFF, "R4");
    rd_reg(2'd2, "R4");
    // R3: clear-mask
    wr_reg(2'd1, 32'h0000_0001, "R3");
    rd_reg(2'd2, "R3");
    // R11: write-only addresses and idle read
    rd_reg(2'd0, "R11");
    rd_reg(2'd1, "R11");
    cyc(0, 0, 2'd2, '0, '0, 0, 0, 0, "R11");
    // R6: low raw flags are sticky
    cyc(0, 0, 2'd0, '0, 32'h0000_0006, 0, 0, 0, "R6");
    rd_reg(2'd3, "R6");
    rd_reg(2'd3, "R6");
    // R12: unused raw bits ignored
    cyc(0, 0, 2'd0, '0, 32'hFFFF_DFE0 & ~32'h0000_2000, 0, 0, 0, "R12");
    rd_reg(2'd3, "R12");
    // R7: transmit trigger moves to bit 10, mask bit 10 set -> irq (R10)
    cyc(0, 0, 2'd0, '0, 32'h0000_2000, 0, 0, 0, "R7");
    rd_reg(2'd3, "R7");
    rd_reg(2'd3, "R10");
    // R8: event pulses
    cyc(0, 0, 2'd0, '0, '0, 1, 0, 0, "R8");
    cyc(0, 0, 2'd0, '0, '0, 0, 1, 0, "R8");
    cyc(0, 0, 2'd0, '0, '0, 0, 0, 1, "R8");
    rd_reg(2'd3, "R8");
    // R5: write-one-to-clear
    wr_reg(2'd3, 32'h0000_0004, "R5");
    rd_reg(2'd3, "R5");
    // R9: set wins, level flag and pulse
    cyc(1, 0, 2'd3, 32'h0000_0022, 32'h0000_0002, 1, 0, 0, "R9");
    rd_reg(2'd3, "R9");
    // R10: clearing drops irq one clock later
    wr_reg(2'd3, 32'hFFFF_FFFF, "R10");
    rd_reg(2'd3, "R10");
    rd_reg(2'd3, "R10");
    // random mix
    begin
      void'($urandom(32'h1234));
      for (int i = 0; i < 400; i++) begin
        logic [W-1:0] rv, dv;
        rv = $urandom & 32'h0000_3FFF;
        if ($urandom_range(0, 2) != 0) rv = '0;
        dv = $urandom & 32'h0000_3FFF;
        cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
            2'($urandom_range(0, 3)), dv, rv,
            $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
            $urandom_range(0, 7) == 0, "R10");
      end
    end
    finish_run();
  end
endmodule